// File: doc/BRIEF.md
# PS/2 Host Link Engine

This block is the bit-level host side of a PS/2 keyboard or mouse link. It watches the open-drain clock and data lines through a synchroniser, assembles 11-bit frames sent by the device, and checks their odd parity and stop bit. A good byte goes into a one-byte holding register. A byte handed in by the host is serialised back to the device with the request-to-send sequence, and the engine samples the device's acknowledge bit at the end. The pad drivers are not part of the block. Each line appears as a sampled input plus an output enable, and the enable pulls the line low when set.

Received bytes leave on a valid/ready stream. `rx_valid` rises when a frame is accepted. It then stays high with `rx_data` held until a cycle in which `rx_ready` is also high. While a byte waits there, the engine holds the device clock low, so the device cannot send and no byte is lost. Bytes to transmit enter on a second valid/ready stream. `tx_ready` is high only when both directions are idle and the holding register is empty, so a byte offered at any other time waits. The transfer starts on the cycle after the handshake. A plain `abort` pin stops any running transfer. Two status pins (`link_writing`, `link_active`) and an acknowledge-error flag (`tx_nack`) report what the link is doing.

Top module: `ps2_host_engine`

## Requirements
- R1: A device frame of 11 bits, taken on falling edges of the synchronised clock (start 0, eight data bits LSB first, odd parity, stop 1), sets `rx_valid` with the byte on `rx_data` within 4 clock cycles of the last falling edge.
- R2: A frame whose nine data-plus-parity bits hold an even number of ones, or whose stop bit is 0, is dropped, and `rx_valid` stays low.
- R3: A falling clock edge while data is high is not taken as a start bit, and `link_active` stays low.
- R4: While `rx_valid` is high, `ps2_clk_oe` is 1, so the clock is held low. The first clock edge with `rx_valid` and `rx_ready` both high clears `rx_valid`, and the clock is released in the next cycle.
- R5: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` do not change.
- R6: `tx_ready` is high only when no transfer is running and `rx_valid` is low. A handshake makes `ps2_clk_oe` 1 for INHIBIT_CYCLES+1 cycles with `ps2_dat_oe` 0 except in the last of those cycles, where both are 1. After that the clock is released and the data line stays driven low as the start bit.
- R7: After the start bit, the engine presents one bit on each falling device clock edge: the eight data bits LSB first, then odd parity, then a released (high) stop bit.
- R8: On the 11th falling edge of a transmit frame, the engine samples the data line. `tx_nack` becomes 1 if the line was high and 0 if it was low. `tx_nack` is cleared at the next transmit handshake.
- R9: One cycle of `abort` stops any receive or transmit in progress. `link_active` is 0 in the next cycle, both output enables drop except the receive inhibit, and the next complete frame is received correctly.
- R10: `link_writing` is 1 only while a host-to-device transfer runs. `link_active` is 1 during any transfer, and is 0 when the link is idle.
- R11: After reset, `rx_valid`, both output enables, `link_writing`, `link_active` and `tx_nack` are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Sampled level of the PS/2 clock line |
| ps2_dat_i | input | 1 | Sampled level of the PS/2 data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Byte offered for transmit |
| tx_ready | output | 1 | Engine can accept a transmit byte |
| tx_data | input | 8 | Byte to transmit |
| abort | input | 1 | Stop all transfers and return to idle |
| link_writing | output | 1 | Host-to-device transfer in progress |
| link_active | output | 1 | Any transfer in progress |
| tx_nack | output | 1 | Last transmit saw no acknowledge |

## Verification
The hardest case to reach from the ports is a device that wants to send while a byte is already held. The stimulus leaves one good byte unread and then starts a second frame from the device model. The model waits while it sees the clock held low. The bench confirms that the clock stays inhibited and that `tx_ready` stays low. It then takes the first byte and checks that the second frame arrives intact. Aborts are injected halfway through a receive frame and during the transmit inhibit period, and each abort is followed by a clean frame. This shows that no bit counter carries stale state into the next frame.

// File: rtl/ps2_link_pkg.sv
package ps2_link_pkg;
  localparam int FRAME_BITS = 11;
  localparam int PAYLOAD_BITS = 9;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_INHIB = 2'd1,
    TX_START = 2'd2,
    TX_SHIFT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] level_o,
  output logic [LINES-1:0] fall_o
);
  logic [LINES-1:0] pipe [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= STAGES; k++) pipe[k] <= '1;
    end else begin
      pipe[0] <= line_i;
      for (int k = 1; k <= STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign level_o = pipe[STAGES-1];
  assign fall_o  = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       abort,
  input  logic       clk_fall,
  input  logic       dat_lvl,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       busy
);
  localparam int CW = $clog2(FRAME_BITS);

  logic [CW-1:0]           bit_cnt;
  logic [PAYLOAD_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (abort || !enable) begin
        bit_cnt <= '0;
      end else if (clk_fall && !rx_valid) begin
        if (bit_cnt == '0) begin
          if (!dat_lvl) bit_cnt <= CW'(1);
        end else if (bit_cnt < CW'(FRAME_BITS - 1)) begin
          shreg   <= {dat_lvl, shreg[PAYLOAD_BITS-1:1]};
          bit_cnt <= bit_cnt + CW'(1);
        end else begin
          bit_cnt <= '0;
          if (dat_lvl && (^shreg)) begin
            rx_valid <= 1'b1;
            rx_data  <= shreg[7:0];
          end
        end
      end
    end
  end

  assign busy = (bit_cnt != '0);

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_abort_clears_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);
endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame
  import ps2_link_pkg::*;
#(
  parameter int INHIBIT_CYCLES = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start_ok,
  input  logic       clk_fall,
  input  logic       dat_lvl,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic       busy,
  output logic       nack
);
  localparam int TW = $clog2(INHIBIT_CYCLES + 1);
  localparam int SW = PAYLOAD_BITS + 1;
  localparam int CW = $clog2(SW + 1);

  tx_state_e     state;
  logic [TW-1:0] tmr;
  logic [SW-1:0] shreg;
  logic [CW-1:0] bit_cnt;
  logic          out_bit;

  assign tx_ready = (state == TX_IDLE) && start_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      tmr     <= '0;
      shreg   <= '0;
      bit_cnt <= '0;
      out_bit <= 1'b1;
      nack    <= 1'b0;
    end else if (abort) begin
      state   <= TX_IDLE;
      out_bit <= 1'b1;
    end else begin
      unique case (state)
        TX_IDLE: if (tx_valid && tx_ready) begin
          shreg   <= {1'b1, ~(^tx_data), tx_data};
          tmr     <= '0;
          nack    <= 1'b0;
          out_bit <= 1'b1;
          state   <= TX_INHIB;
        end
        TX_INHIB: begin
          tmr <= tmr + TW'(1);
          if (tmr == TW'(INHIBIT_CYCLES - 1)) begin
            out_bit <= 1'b0;
            state   <= TX_START;
          end
        end
        TX_START: begin
          bit_cnt <= '0;
          state   <= TX_SHIFT;
        end
        TX_SHIFT: if (clk_fall) begin
          if (bit_cnt < CW'(SW)) begin
            out_bit <= shreg[0];
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + CW'(1);
          end else begin
            nack    <= dat_lvl;
            out_bit <= 1'b1;
            state   <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign clk_oe = (state == TX_INHIB) || (state == TX_START);
  assign dat_oe = ((state == TX_START) || (state == TX_SHIFT)) && !out_bit;
  assign busy   = (state != TX_IDLE);

  p_clk_held_in_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe && clk_oe |=> !clk_oe && dat_oe);

  p_drive_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> busy);
endmodule

// File: rtl/ps2_host_engine.sv
module ps2_host_engine #(
  parameter int INHIBIT_CYCLES = 25000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  input  logic       abort,
  output logic       link_writing,
  output logic       link_active,
  output logic       tx_nack
);
  logic [1:0] lvl, fall;
  logic       rx_busy, tx_busy, tx_clk_oe, tx_dat_oe;

  ps2_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .line_i({ps2_dat_i, ps2_clk_i}),
    .level_o(lvl), .fall_o(fall)
  );

  ps2_rx_frame u_rx (
    .clk(clk), .rst_n(rst_n), .enable(!tx_busy), .abort(abort),
    .clk_fall(fall[0]), .dat_lvl(lvl[1]), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(rx_busy)
  );

  ps2_tx_frame #(.INHIBIT_CYCLES(INHIBIT_CYCLES)) u_tx (
    .clk(clk), .rst_n(rst_n), .abort(abort),
    .start_ok(!rx_busy && !rx_valid),
    .clk_fall(fall[0]), .dat_lvl(lvl[1]),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .clk_oe(tx_clk_oe), .dat_oe(tx_dat_oe), .busy(tx_busy), .nack(tx_nack)
  );

  assign ps2_clk_oe   = tx_clk_oe || rx_valid;
  assign ps2_dat_oe   = tx_dat_oe;
  assign link_writing = tx_busy;
  assign link_active  = tx_busy || rx_busy;

  p_inhibit_when_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ps2_clk_oe);

  p_no_tx_while_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_ready);

  p_writing_implies_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_writing |-> link_active);

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !link_active);
endmodule

// File: tb/ps2_host_engine_test.sv
module ps2_host_engine_test;
  localparam int INH = 40;
  localparam int HP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic ps2_clk_i, ps2_dat_i, ps2_clk_oe, ps2_dat_oe;
  logic rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic abort = 1'b0;
  logic link_writing, link_active, tx_nack;

  always #2 clk = ~clk;

  assign ps2_clk_i = dev_clk & ~ps2_clk_oe;
  assign ps2_dat_i = dev_dat & ~ps2_dat_oe;

  ps2_host_engine #(.INHIBIT_CYCLES(INH)) uut (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
    .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .abort(abort), .link_writing(link_writing), .link_active(link_active),
    .tx_nack(tx_nack)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit settle = 1'b0;
  byte unsigned held_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model comparison on every clock while the link is quiet
  always @(negedge clk) begin
    if (rst_n && settle) begin
      chk(rx_valid == (held_q.size() != 0), "R1", "rx_valid vs model",
          int'(rx_valid), int'(held_q.size() != 0));
      if (held_q.size() != 0)
        chk(rx_data == held_q[0], "R5", "held byte", rx_data, held_q[0]);
      chk(ps2_clk_oe == (held_q.size() != 0), "R4", "clock inhibit",
          int'(ps2_clk_oe), int'(held_q.size() != 0));
      chk(!link_active && !link_writing, "R10", "idle flags",
          {link_active, link_writing}, 0);
    end
  end

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      summary_and_end();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // device sends a frame; nbits limits how many bits go out
  task automatic dev_send(input byte unsigned b, input bit bad_par,
                          input bit bad_stop, input int nbits);
    logic [10:0] f;
    logic par;
    par = ~(^b) ^ bad_par;
    f = {~bad_stop, par, b, 1'b0};
    while (ps2_clk_i == 1'b0) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      dev_dat = f[i];
      wait_n(HP);
      dev_clk = 1'b0;
      wait_n(HP);
      dev_clk = 1'b1;
    end
    dev_dat = 1'b1;
    wait_n(6);
  endtask

  // device receives a host frame; returns the 10 sampled bits
  task automatic dev_take(input bit give_ack, output logic [9:0] bits);
    while (!(ps2_clk_oe == 1'b0 && ps2_dat_oe == 1'b1)) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      wait_n(HP);
      dev_clk = 1'b0;
      wait_n(HP);
      dev_clk = 1'b1;
      bits[i] = ps2_dat_i;
    end
    if (give_ack) dev_dat = 1'b0;
    wait_n(HP);
    dev_clk = 1'b0;
    wait_n(HP);
    dev_clk = 1'b1;
    dev_dat = 1'b1;
    wait_n(6);
  endtask

  task automatic host_offer(input byte unsigned b);
    @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic host_consume(input string req);
    @(negedge clk);
    chk(rx_valid == 1'b1, req, "byte present", int'(rx_valid), 1);
    if (held_q.size() != 0)
      chk(rx_data == held_q[0], req, "byte value", rx_data, held_q[0]);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    if (held_q.size() != 0) void'(held_q.pop_front());
    chk(rx_valid == 1'b0, "R4", "valid cleared after take", int'(rx_valid), 0);
    chk(ps2_clk_oe == 1'b0, "R4", "clock released after take", int'(ps2_clk_oe), 0);
  endtask

  task automatic do_tx(input byte unsigned b, input bit give_ack);
    logic [9:0] bits;
    int hi;
    settle = 1'b0;
    fork
      host_offer(b);
      begin
        hi = 0;
        while (ps2_clk_oe == 1'b0) @(negedge clk);
        while (ps2_clk_oe == 1'b1) begin
          chk(link_writing && link_active, "R10", "flags during transmit",
              {link_writing, link_active}, 3);
          if (ps2_dat_oe) chk(hi == INH, "R6", "data low only in last held cycle", hi, INH);
          hi++;
          @(negedge clk);
        end
        chk(hi == INH + 1, "R6", "clock hold length", hi, INH + 1);
        chk(ps2_dat_oe == 1'b1, "R6", "start bit driven", int'(ps2_dat_oe), 1);
      end
      dev_take(give_ack, bits);
    join
    chk(bits[7:0] == b, "R7", "data bits LSB first", bits[7:0], b);
    chk(bits[8] == ~(^b), "R7", "odd parity", int'(bits[8]), int'(~(^b)));
    chk(bits[9] == 1'b1, "R7", "stop released", int'(bits[9]), 1);
    chk(tx_nack == !give_ack, "R8", "acknowledge result", int'(tx_nack), int'(!give_ack));
    settle = 1'b1;
  endtask

  task automatic rx_good(input byte unsigned b);
    settle = 1'b0;
    dev_send(b, 1'b0, 1'b0, 11);
    held_q.push_back(b);
    chk(rx_valid && rx_data == b, "R1", "frame received", rx_data, b);
    settle = 1'b1;
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rx_valid && !ps2_clk_oe && !ps2_dat_oe && !link_writing && !link_active
        && !tx_nack && tx_ready, "R11", "reset state",
        {rx_valid, ps2_clk_oe, ps2_dat_oe, link_writing, link_active, tx_nack, tx_ready},
        7'b0000001);
    settle = 1'b1;
    wait_n(5);

    // R1 with several patterns, each taken after wait (R5 checked by model)
    rx_good(8'hA5); wait_n(20); host_consume("R1");
    rx_good(8'h00); host_consume("R1");
    rx_good(8'hFF); host_consume("R1");
    rx_good(8'h01); host_consume("R1");

    // R2 bad parity and bad stop
    settle = 1'b0;
    dev_send(8'h3C, 1'b1, 1'b0, 11);
    chk(!rx_valid, "R2", "bad parity dropped", int'(rx_valid), 0);
    dev_send(8'h5A, 1'b0, 1'b1, 11);
    chk(!rx_valid, "R2", "bad stop dropped", int'(rx_valid), 0);
    settle = 1'b1;
    rx_good(8'h81); host_consume("R2");

    // R3 falling edge with data high is no start
    settle = 1'b0;
    dev_dat = 1'b1; wait_n(HP); dev_clk = 1'b0; wait_n(HP); dev_clk = 1'b1; wait_n(6);
    chk(!link_active, "R3", "no start on high data", int'(link_active), 0);
    settle = 1'b1;
    rx_good(8'h42); host_consume("R3");

    // R4/R6 device tries to send while full
    rx_good(8'h96);
    settle = 1'b0;
    fork
      dev_send(8'h69, 1'b0, 1'b0, 11);
      begin
        wait_n(60);
        chk(ps2_clk_i == 1'b0, "R4", "line held low while full", int'(ps2_clk_i), 0);
        chk(!tx_ready, "R6", "no transmit while full", int'(tx_ready), 0);
        host_consume("R4");
      end
    join
    held_q.push_back(8'h69);
    chk(rx_valid && rx_data == 8'h69, "R4", "second frame after release", rx_data, 8'h69);
    settle = 1'b1;
    host_consume("R4");

    // R6..R8 transmit with and without acknowledge
    do_tx(8'hED, 1'b1);
    do_tx(8'hF4, 1'b0);
    do_tx(8'h00, 1'b1);

    // R9 abort mid receive
    settle = 1'b0;
    dev_send(8'hC3, 1'b0, 1'b0, 5);
    chk(link_active, "R10", "active during receive", int'(link_active), 1);
    chk(!link_writing, "R10", "not writing during receive", int'(link_writing), 0);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!link_active, "R9", "abort ends receive", int'(link_active), 0);
    wait_n(4);
    settle = 1'b1;
    rx_good(8'h7E); host_consume("R9");

    // R9 abort during transmit inhibit
    settle = 1'b0;
    @(negedge clk); tx_data = 8'h11; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    wait_n(10);
    chk(ps2_clk_oe && link_writing, "R6", "inhibit started", {ps2_clk_oe, link_writing}, 3);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    chk(!link_active && !ps2_clk_oe && !ps2_dat_oe, "R9", "abort ends transmit",
        {link_active, ps2_clk_oe, ps2_dat_oe}, 0);
    chk(tx_ready, "R9", "ready after abort", int'(tx_ready), 1);
    wait_n(4);
    settle = 1'b1;
    do_tx(8'h11, 1'b1);
    rx_good(8'hBE); host_consume("R9");

    wait_n(10);
    summary_and_end();
  end
endmodule